// File: doc/BRIEF.md
# Main-Oscillator Stall Detector with Clock Failover

This block runs from a free-running backup on-chip clock and watches the main oscillator. A toggle flop in the main-clock domain is carried into the backup domain through a synchronizer chain. A counter measures how long that synchronized level has gone without changing. When the count runs out while detection is armed, the block takes four actions. It moves the system clock selection to the backup oscillator. It forces the low-speed backup oscillator to run. It latches a stop flag. It raises an interrupt request.

Software controls the block through one whole-register write port. The same port arms detection, picks the high-speed or low-speed backup oscillator for use after failover, and clears the latched flag. It also moves the clock selection back to the main oscillator once software has confirmed that the oscillator runs again. The interrupt line is shared with a watchdog request and a voltage-monitor request, so a three-bit cause vector is also provided. The block drives only select and enable controls. The oscillators, the glitch-free clock multiplexer and the CPU sit outside it.

Top module: `osd_failover_top`

## Requirements
- R1: Detection is armed only while the enable field (write-data bits [1:0]) holds 2'b11. With any other value, a stalled main clock never sets the stop flag.
- R2: A detected stall sets `sel_bkp` to 1, meaning the backup oscillator drives the system clock.
- R3: A detected stall sets `stop_flag` to 1.
- R4: A detected stall forces `lso_run` to 1, even if software had stopped the low-speed oscillator by writing 1 to bit 3.
- R5: `irq_cause` is {vmon_req, wdt_req, stop_flag} (bit 0 is the stall). `irq_out` is 1 whenever any cause bit is 1.
- R6: Bit 2 of a write sets `bkp_hs`: 0 means the low-speed backup oscillator is used after failover, and 1 means the high-speed one.
- R7: `stop_flag` and `sel_bkp` stay latched after the main clock resumes. Neither reverts without a write.
- R8: A write with bit 4 set, or a write with enable field 2'b00, clears `stop_flag`. Such a write leaves `sel_bkp` unchanged.
- R9: A write with bit 5 set returns `sel_bkp` to 0, which selects the main clock. Only this write clears `sel_bkp`.
- R10: After the main clock stops, the stop flag does not rise before STOP_LIMIT backup cycles have passed. It rises no later than STOP_LIMIT+SYNC_STAGES+4 backup cycles after the stop.
- R11: While the main clock runs at no less than one edge per STOP_LIMIT/2 backup cycles, no stall is flagged.
- R12: Every register write restarts the silence counter. If writes come closer together than STOP_LIMIT cycles, no stall is flagged.
- R13: Reset leaves the enable field at 2'b00, `sel_bkp`, `stop_flag` and `irq_out` at 0, and the low-speed oscillator running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bkp | input | 1 | Free-running backup oscillator clock; all registers except the toggle run on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_main | input | 1 | Main oscillator clock being watched |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 6 | Write data: [1:0] enable, [2] backup speed, [3] stop low-speed osc, [4] clear flag, [5] return to main |
| wdt_req | input | 1 | Watchdog interrupt request sharing the vector |
| vmon_req | input | 1 | Voltage-monitor interrupt request sharing the vector |
| en_q | output | 2 | Current enable field |
| sel_bkp | output | 1 | 1 = system clock taken from the backup oscillator |
| bkp_hs | output | 1 | 1 = high-speed backup oscillator selected |
| lso_run | output | 1 | Run control for the low-speed backup oscillator |
| stop_flag | output | 1 | Latched main-clock stall status |
| irq_out | output | 1 | Shared interrupt request |
| irq_cause | output | 3 | Cause vector {vmon, wdt, stall} |

## Verification
A stall can be latched in the same cycle that a watchdog or voltage-monitor request is already pending. In that case the shared line must show one request, and the cause vector must carry both bits. The bench holds each of the four external request patterns while the flag is set, and again after it is cleared, and checks every cause bit and the line against the OR computed in the bench. A second overlap is a register write landing where the counter would expire. The bench provokes it by repeating the arming write every few cycles while the main clock is stopped, then expects no flag until the writes stop.

// File: rtl/osd_pkg.sv
package osd_pkg;
   // write-data field positions
   localparam int unsigned EN_LSB   = 0;
   localparam int unsigned EN_W     = 2;
   localparam int unsigned HS_BIT   = 2;
   localparam int unsigned LSOFF_BIT = 3;
   localparam int unsigned CLR_BIT  = 4;
   localparam int unsigned RET_BIT  = 5;
   localparam int unsigned CFG_W    = 6;

   localparam logic [EN_W-1:0] EN_ARMED = 2'b11;
   localparam logic [EN_W-1:0] EN_OFF   = 2'b00;

   // cause vector positions
   localparam int unsigned CAUSE_STALL = 0;
   localparam int unsigned CAUSE_WDT   = 1;
   localparam int unsigned CAUSE_VMON  = 2;
   localparam int unsigned CAUSE_W     = 3;

   typedef struct packed {
      logic            ret_main;
      logic            clr_flag;
      logic            lso_off;
      logic            hs_sel;
      logic [EN_W-1:0] en;
   } cfg_word_t;
endpackage

// File: rtl/osd_toggle_src.sv
module osd_toggle_src (
   input  logic clk_main,
   input  logic rst_n,
   output logic tgl
);
   // flips on every main-clock edge; its level is what crosses domains
   always_ff @(posedge clk_main or negedge rst_n) begin
      if (!rst_n) tgl <= 1'b0;
      else        tgl <= ~tgl;
   end
endmodule

// File: rtl/osd_sync.sv
module osd_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   initial begin
      if (STAGES < 2) $fatal(1, "osd_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= d;
   end

   for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[gi] <= 1'b0;
         else        chain[gi] <= chain[gi-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/osd_watch.sv
module osd_watch #(
   parameter int unsigned STOP_LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic restart,
   input  logic smp,
   output logic stop_det
);
   localparam int unsigned CNT_W = (STOP_LIMIT > 2) ? $clog2(STOP_LIMIT) : 1;
   localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(STOP_LIMIT - 1);

   logic             prev;
   logic             seen;
   logic [CNT_W-1:0] cnt;

   initial begin
      if (STOP_LIMIT < 2) $fatal(1, "osd_watch: STOP_LIMIT must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= smp;
   end

   always_comb begin
      seen     = smp ^ prev;
      stop_det = armed && !restart && !seen && (cnt == LIM_M1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart || !armed || seen || stop_det)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/osd_regs.sv
module osd_regs
   import osd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             stop_det,
   output logic [EN_W-1:0]  en_q,
   output logic             hs_q,
   output logic             sel_q,
   output logic             flag_q,
   output logic             lso_off_q,
   output logic             armed
);
   cfg_word_t wr;
   logic      drop_flag;

   always_comb begin
      wr        = cfg_word_t'(cfg_wdata);
      drop_flag = wr.clr_flag || (wr.en == EN_OFF);
      armed     = (en_q == EN_ARMED);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= EN_OFF;
         hs_q      <= 1'b0;
         sel_q     <= 1'b0;
         flag_q    <= 1'b0;
         lso_off_q <= 1'b0;
      end else begin
         if (cfg_we) begin
            en_q      <= wr.en;
            hs_q      <= wr.hs_sel;
            lso_off_q <= wr.lso_off;
            if (drop_flag)   flag_q <= 1'b0;
            if (wr.ret_main) sel_q  <= 1'b0;
         end
         // a write restarts the counter, so a detection never shares its cycle
         if (stop_det) begin
            flag_q    <= 1'b1;
            sel_q     <= 1'b1;
            lso_off_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/osd_failover_top.sv
module osd_failover_top
   import osd_pkg::*;
#(
   parameter int unsigned STOP_LIMIT  = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk_bkp,
   input  logic                rst_n,
   input  logic                clk_main,
   input  logic                cfg_we,
   input  logic [CFG_W-1:0]    cfg_wdata,
   input  logic                wdt_req,
   input  logic                vmon_req,
   output logic [EN_W-1:0]     en_q,
   output logic                sel_bkp,
   output logic                bkp_hs,
   output logic                lso_run,
   output logic                stop_flag,
   output logic                irq_out,
   output logic [CAUSE_W-1:0]  irq_cause
);
   logic tgl;
   logic tgl_s;
   logic stop_det;
   logic armed;
   logic lso_off;

   osd_toggle_src i_tgl (
      .clk_main (clk_main),
      .rst_n    (rst_n),
      .tgl      (tgl)
   );

   osd_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk_bkp),
      .rst_n (rst_n),
      .d     (tgl),
      .q     (tgl_s)
   );

   osd_watch #(.STOP_LIMIT(STOP_LIMIT)) i_watch (
      .clk      (clk_bkp),
      .rst_n    (rst_n),
      .armed    (armed),
      .restart  (cfg_we),
      .smp      (tgl_s),
      .stop_det (stop_det)
   );

   osd_regs i_regs (
      .clk       (clk_bkp),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .stop_det  (stop_det),
      .en_q      (en_q),
      .hs_q      (bkp_hs),
      .sel_q     (sel_bkp),
      .flag_q    (stop_flag),
      .lso_off_q (lso_off),
      .armed     (armed)
   );

   always_comb begin
      lso_run                 = !lso_off;
      irq_cause               = '0;
      irq_cause[CAUSE_STALL]  = stop_flag;
      irq_cause[CAUSE_WDT]    = wdt_req;
      irq_cause[CAUSE_VMON]   = vmon_req;
      irq_out                 = |irq_cause;
   end
endmodule

// File: rtl/osd_failover_chk.sv
module osd_failover_chk
   import osd_pkg::*;
(
   input logic             clk_bkp,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [CFG_W-1:0] cfg_wdata,
   input logic [EN_W-1:0]  en_q,
   input logic             sel_bkp,
   input logic             lso_run,
   input logic             stop_flag,
   input logic             irq_out
);
   assert_armed_before_set_R1: assert property (@(posedge clk_bkp) disable iff (!rst_n)
      $rose(stop_flag) |-> ($past(en_q) == EN_ARMED))
      else $error("stall flagged while not armed");

   assert_failover_sel_R2: assert property (@(posedge clk_bkp) disable iff (!rst_n)
      $rose(stop_flag) |-> sel_bkp)
      else $error("stall without failover select");

   assert_set_not_on_write_R3: assert property (@(posedge clk_bkp) disable iff (!rst_n)
      $rose(stop_flag) |-> !$past(cfg_we))
      else $error("stall flagged in a write cycle");

   assert_lso_forced_R4: assert property (@(posedge clk_bkp) disable iff (!rst_n)
      $rose(stop_flag) |-> lso_run)
      else $error("low-speed oscillator not forced on");

   assert_irq_follows_flag_R5: assert property (@(posedge clk_bkp) disable iff (!rst_n)
      stop_flag |-> irq_out)
      else $error("flag set without request");

   assert_sel_holds_R7: assert property (@(posedge clk_bkp) disable iff (!rst_n)
      (sel_bkp && !cfg_we) |=> sel_bkp)
      else $error("select reverted without a write");

   assert_flag_clear_by_write_R8: assert property (@(posedge clk_bkp) disable iff (!rst_n)
      $fell(stop_flag) |-> $past(cfg_we))
      else $error("flag dropped without a write");

   assert_return_by_write_R9: assert property (@(posedge clk_bkp) disable iff (!rst_n)
      $fell(sel_bkp) |-> $past(cfg_we && cfg_wdata[RET_BIT]))
      else $error("select cleared without return write");
endmodule

bind osd_failover_top osd_failover_chk i_chk (
   .clk_bkp   (clk_bkp),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .en_q      (en_q),
   .sel_bkp   (sel_bkp),
   .lso_run   (lso_run),
   .stop_flag (stop_flag),
   .irq_out   (irq_out)
);

// File: tb/test_osd_failover_top.sv
module test_osd_failover_top;
   localparam int CLK_PERIOD = 10;
   localparam int MAIN_HALF  = 15;
   localparam int LIMIT      = 8;
   localparam int SYNC       = 2;

   logic       clk_bkp = 1'b0;
   logic       clk_main = 1'b0;
   logic       main_run = 1'b1;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [5:0] cfg_wdata = '0;
   logic       wdt_req = 1'b0;
   logic       vmon_req = 1'b0;
   logic [1:0] en_q;
   logic       sel_bkp, bkp_hs, lso_run, stop_flag, irq_out;
   logic [2:0] irq_cause;

   int vecs = 0;
   int errs = 0;

   always #(CLK_PERIOD/2) clk_bkp = ~clk_bkp;
   always begin
      #MAIN_HALF;
      if (main_run) clk_main = ~clk_main;
   end

   osd_failover_top #(.STOP_LIMIT(LIMIT), .SYNC_STAGES(SYNC)) i_osd_failover_top (
      .clk_bkp   (clk_bkp),
      .rst_n     (rst_n),
      .clk_main  (clk_main),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .wdt_req   (wdt_req),
      .vmon_req  (vmon_req),
      .en_q      (en_q),
      .sel_bkp   (sel_bkp),
      .bkp_hs    (bkp_hs),
      .lso_run   (lso_run),
      .stop_flag (stop_flag),
      .irq_out   (irq_out),
      .irq_cause (irq_cause)
   );

   task automatic chk(input string req, input int act, input int exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] d);
      @(negedge clk_bkp);
      cfg_we = 1'b1;
      cfg_wdata = d;
      @(negedge clk_bkp);
      cfg_we = 1'b0;
      cfg_wdata = '0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk_bkp);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errs++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(1);
      // R13 reset state
      chk("R13 en", en_q, 0);
      chk("R13 sel", sel_bkp, 0);
      chk("R13 flag", stop_flag, 0);
      chk("R13 irq", irq_out, 0);
      chk("R13 lso", lso_run, 1);

      // R11 running clock, armed, no false detection
      wr(6'b000011);
      wait_cyc(200);
      chk("R11 flag", stop_flag, 0);
      chk("R11 sel", sel_bkp, 0);

      // R4 stop low-speed osc first, then stall
      wr(6'b001011);
      chk("R4 lso off", lso_run, 0);
      main_run = 1'b0;
      wait_cyc(6);
      chk("R10 early", stop_flag, 0);
      wait_cyc(LIMIT + SYNC + 4 - 6);
      chk("R3 flag", stop_flag, 1);
      chk("R2 sel", sel_bkp, 1);
      chk("R4 lso forced", lso_run, 1);
      chk("R5 irq", irq_out, 1);
      chk("R5 cause", irq_cause, 3'b001);

      // R6 speed select, plain write keeps flag (R7)
      wr(6'b000111);
      chk("R6 hs", bkp_hs, 1);
      chk("R7 flag kept", stop_flag, 1);
      wr(6'b000011);
      chk("R6 ls", bkp_hs, 0);

      // R5 cause sweep with flag set
      for (int c = 0; c < 4; c++) begin
         @(negedge clk_bkp);
         wdt_req = c[0];
         vmon_req = c[1];
         @(negedge clk_bkp);
         chk("R5 cause w/flag", irq_cause, {c[1], c[0], 1'b1});
         chk("R5 irq w/flag", irq_out, 1);
      end
      wdt_req = 1'b0;
      vmon_req = 1'b0;

      // R7 main resumes, status latched
      main_run = 1'b1;
      wait_cyc(30);
      chk("R7 flag", stop_flag, 1);
      chk("R7 sel", sel_bkp, 1);

      // R8 clear bit
      wr(6'b010011);
      chk("R8 flag clr", stop_flag, 0);
      chk("R8 irq clr", irq_out, 0);
      chk("R8 sel kept", sel_bkp, 1);
      wait_cyc(30);
      chk("R8 stays clear", stop_flag, 0);

      // R5 cause sweep with flag clear
      for (int c = 0; c < 4; c++) begin
         @(negedge clk_bkp);
         wdt_req = c[0];
         vmon_req = c[1];
         @(negedge clk_bkp);
         chk("R5 cause", irq_cause, {c[1], c[0], 1'b0});
         chk("R5 irq", irq_out, (c != 0) ? 1 : 0);
      end
      wdt_req = 1'b0;
      vmon_req = 1'b0;

      // R9 return to main
      wr(6'b100011);
      chk("R9 sel", sel_bkp, 0);
      chk("R9 flag", stop_flag, 0);

      // R8 clear through enable 00
      main_run = 1'b0;
      wait_cyc(LIMIT + SYNC + 4);
      chk("R8 set again", stop_flag, 1);
      wr(6'b000000);
      chk("R8 en00 flag", stop_flag, 0);
      chk("R8 en00 sel", sel_bkp, 1);
      chk("R8 en00 en", en_q, 0);
      wr(6'b100000);
      chk("R9 sel back", sel_bkp, 0);
      main_run = 1'b1;
      wait_cyc(10);

      // R1 sweep of the enable field
      for (int v = 0; v < 4; v++) begin
         wr(6'b010000 | 6'(v));
         chk("R1 en readback", en_q, v);
         main_run = 1'b0;
         wait_cyc(3 * LIMIT);
         chk("R1 flag", stop_flag, (v == 3) ? 1 : 0);
         chk("R1 sel", sel_bkp, (v == 3) ? 1 : 0);
         wr(6'b110000);
         main_run = 1'b1;
         wait_cyc(10);
      end

      // R12 repeated writes restart the counter
      wr(6'b000011);
      main_run = 1'b0;
      for (int k = 0; k < 10; k++) begin
         wait_cyc(3);
         wr(6'b000011);
      end
      chk("R12 no flag", stop_flag, 0);
      wait_cyc(LIMIT + SYNC + 4);
      chk("R12 flag after", stop_flag, 1);
      wr(6'b110000);
      main_run = 1'b1;
      wait_cyc(5);
      chk("R9 final sel", sel_bkp, 0);

      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule